// File: doc/BRIEF.md
# Privileged Model-Specific Register Access Unit

This unit sits between a processor's register-access instructions and the registers they reach through a 32-bit index. Each request carries an index, a read/write flag, 64 bits of write data and the current privilege level. The unit accepts the request only if the privilege level is 0 and the index is one it implements. Otherwise it answers with a general protection fault whose error code is zero.

Accepted indices are handled in one of two ways. Some are served from storage inside the unit: the machine-check address and type records, eleven scratch test registers and a 4-bit trace-control register. The others are passed on, in the same cycle, to the time-stamp counter and the performance-monitoring block. Those blocks return their read data combinationally.

A separate machine-check capture strobe records the faulting physical address and the bus-cycle attributes, and sets a check flag. A successful read of the type record clears that flag. Every request gets exactly one response one clock after it is presented.

Top module: `msr_access_unit`

## Requirements
- R1: Indices 0x0-0x2, 0x4-0xE and 0x10-0x13 are accepted. Index 0x3, index 0xF and every index above 0x13, including any with upper bits set, produce a fault.
- R2: A request with a privilege level other than 0 faults whatever its index. It changes no local register and does not raise `ext_valid`.
- R3: A request presented in cycle N gets a response with `rsp_valid` high in cycle N+1 only. A faulted response carries all-zero data. A write that is accepted responds with `rsp_fault` low and zero data.
- R4: Index 0x0 reads the last captured 32-bit address in bits 31..0, with bits 63..32 reading zero. Writes to it are accepted without fault but change nothing.
- R5: Index 0x1 reads lock in bit 4, memory/IO in bit 3, data/code in bit 2, write/read in bit 1 and the check flag in bit 0, with bits 63..5 reading zero. Writes to it are accepted but change nothing.
- R6: A capture strobe sets the check flag. An accepted read of index 0x1 returns the flag and then clears it. When a capture and such a read fall in the same cycle, the flag stays set.
- R7: Indices 0x2 and 0x4-0xD are independent 64-bit registers that read back the last value written to them.
- R8: Index 0xE stores bits 3..0, with bit 1 being the trace enable. Bits 63..4 of a write are discarded and read as zero.
- R9: Accepted requests to 0x10, 0x11, 0x12 and 0x13 pulse `ext_valid` in the request cycle with `ext_sel` set to 0, 1, 2 and 3 respectively. `ext_write` and `ext_wdata` follow the request, and a read returns the `ext_rdata` present in that cycle.
- R10: After reset, every local register reads zero and `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_index | input | 32 | Register index |
| req_priv | input | 2 | Current privilege level |
| req_wdata | input | 64 | Write data |
| mc_capture | input | 1 | Machine-check capture strobe |
| mc_addr | input | 32 | Faulting physical address |
| mc_lock | input | 1 | Checked bus cycle was locked |
| mc_mio | input | 1 | Memory/IO pin state |
| mc_dc | input | 1 | Data/code pin state |
| mc_wr | input | 1 | Write/read pin state |
| ext_valid | output | 1 | Forwarded access strobe |
| ext_write | output | 1 | Forwarded access is a write |
| ext_sel | output | 2 | 0 time stamp, 1 event select, 2 counter 0, 3 counter 1 |
| ext_wdata | output | 64 | Forwarded write data |
| ext_rdata | input | 64 | Read data from the forwarded target, same cycle |
| rsp_valid | output | 1 | Response cycle |
| rsp_fault | output | 1 | General protection fault, error code zero |
| rsp_rdata | output | 64 | Read data |

## Verification
The assertions assume that `req_index` and `req_priv` hold steady throughout any cycle in which `req_valid` is high. They also assume that `ext_rdata` is a pure function of `ext_sel` within a cycle. The bench changes inputs only on falling edges and models the forwarded targets as a fixed function of `ext_sel`, so both assumptions hold. Capture strobes are driven either alone or deliberately together with a read of the type record, which exercises the case where a set and a clear land in the same cycle.

// File: rtl/msr_pkg.sv
// Package: shared index constants and target classification for the
// register access unit. Assumes the fixed index map of the unit.
package msr_pkg;
    localparam int unsigned IDX_W        = 32;
    localparam int unsigned XLEN         = 64;
    localparam int unsigned NUM_TEST     = 11;
    localparam int unsigned SLOT_W       = $clog2(NUM_TEST);
    localparam int unsigned EXT_SEL_W    = 2;
    localparam int unsigned MCTYPE_BITS  = 5;

    localparam logic [IDX_W-1:0] IX_MCADDR  = 32'h0;
    localparam logic [IDX_W-1:0] IX_MCTYPE  = 32'h1;
    localparam logic [IDX_W-1:0] IX_TEST0   = 32'h2;
    localparam logic [IDX_W-1:0] IX_TESTLO  = 32'h4;
    localparam logic [IDX_W-1:0] IX_TESTHI  = 32'hD;
    localparam logic [IDX_W-1:0] IX_TRACE   = 32'hE;
    localparam logic [IDX_W-1:0] IX_EXTLO   = 32'h10;
    localparam logic [IDX_W-1:0] IX_EXTHI   = 32'h13;

    typedef enum logic [2:0] {
        TGT_NONE   = 3'd0,
        TGT_MCADDR = 3'd1,
        TGT_MCTYPE = 3'd2,
        TGT_TEST   = 3'd3,
        TGT_TRACE  = 3'd4,
        TGT_EXT    = 3'd5
    } msr_tgt_e;
endpackage

// File: rtl/msr_index_decode.sv
// Index decoder: classifies a 32-bit index into a target kind, a test
// register slot and a forwarding select. Purely combinational; any index
// outside the implemented map yields TGT_NONE.
module msr_index_decode
    import msr_pkg::*;
(
    input  logic [IDX_W-1:0]     index,
    output msr_tgt_e             tgt,
    output logic [SLOT_W-1:0]    slot,
    output logic [EXT_SEL_W-1:0] sel
);
    logic [IDX_W-1:0] slot_wide;
    logic [IDX_W-1:0] sel_wide;

    assign slot_wide = index - 32'd3;
    assign sel_wide  = index - IX_EXTLO;

    // Classify the index against the implemented map.
    always_comb begin
        tgt  = TGT_NONE;
        slot = '0;
        sel  = '0;
        if (index == IX_MCADDR) begin
            tgt = TGT_MCADDR;
        end else if (index == IX_MCTYPE) begin
            tgt = TGT_MCTYPE;
        end else if (index == IX_TEST0) begin
            tgt = TGT_TEST;
        end else if (index >= IX_TESTLO && index <= IX_TESTHI) begin
            tgt  = TGT_TEST;
            slot = slot_wide[SLOT_W-1:0];
        end else if (index == IX_TRACE) begin
            tgt = TGT_TRACE;
        end else if (index >= IX_EXTLO && index <= IX_EXTHI) begin
            tgt = TGT_EXT;
            sel = sel_wide[EXT_SEL_W-1:0];
        end
    end
endmodule

// File: rtl/msr_local_regs.sv
// Local register file: machine-check address and type records, scratch
// test registers and the trace-control register. Assumes writes and the
// check-flag clear arrive already qualified by privilege and index.
module msr_local_regs
    import msr_pkg::*;
#(
    parameter int unsigned MCA_W = 32,
    parameter int unsigned TRC_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mc_capture,
    input  logic [MCA_W-1:0]     mc_addr,
    input  logic [3:0]           mc_attr,
    input  logic                 wr_en,
    input  msr_tgt_e             tgt,
    input  logic [SLOT_W-1:0]    slot,
    input  logic [XLEN-1:0]      wdata,
    input  logic                 chk_clr,
    output logic [XLEN-1:0]      rdata
);
    logic [MCA_W-1:0]  mca_q;
    logic [3:0]        attr_q;
    logic              chk_q;
    logic [TRC_W-1:0]  trc_q;
    logic [XLEN-1:0]   test_q [NUM_TEST];

    // Capture address and attributes on a machine check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mca_q  <= '0;
            attr_q <= '0;
        end else if (mc_capture) begin
            mca_q  <= mc_addr;
            attr_q <= mc_attr;
        end
    end

    // Check flag: set by capture, cleared by a read; capture wins.
    always_ff @(posedge clk) begin
        if (!rst_n)          chk_q <= 1'b0;
        else if (mc_capture) chk_q <= 1'b1;
        else if (chk_clr)    chk_q <= 1'b0;
    end

    // Trace control keeps only its implemented low bits.
    always_ff @(posedge clk) begin
        if (!rst_n)                         trc_q <= '0;
        else if (wr_en && tgt == TGT_TRACE) trc_q <= wdata[TRC_W-1:0];
    end

    // One 64-bit scratch register per test slot.
    for (genvar g = 0; g < NUM_TEST; g++) begin : g_test
        always_ff @(posedge clk) begin
            if (!rst_n)
                test_q[g] <= '0;
            else if (wr_en && tgt == TGT_TEST && slot == SLOT_W'(g))
                test_q[g] <= wdata;
        end
    end

    // Read multiplexer over local targets.
    always_comb begin
        rdata = '0;
        case (tgt)
            TGT_MCADDR: rdata[MCA_W-1:0] = mca_q;
            TGT_MCTYPE: rdata[MCTYPE_BITS-1:0] = {attr_q, chk_q};
            TGT_TEST:   rdata = (slot < SLOT_W'(NUM_TEST)) ? test_q[slot] : '0;
            TGT_TRACE:  rdata[TRC_W-1:0] = trc_q;
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/msr_access_unit.sv
// Top: privilege and index checking, local service or forwarding, and a
// single registered response per request. Assumes ext_rdata is valid in
// the same cycle as ext_valid.
module msr_access_unit
    import msr_pkg::*;
#(
    parameter int unsigned MCA_W = 32,
    parameter int unsigned TRC_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [31:0]          req_index,
    input  logic [1:0]           req_priv,
    input  logic [63:0]          req_wdata,
    input  logic                 mc_capture,
    input  logic [31:0]          mc_addr,
    input  logic                 mc_lock,
    input  logic                 mc_mio,
    input  logic                 mc_dc,
    input  logic                 mc_wr,
    output logic                 ext_valid,
    output logic                 ext_write,
    output logic [1:0]           ext_sel,
    output logic [63:0]          ext_wdata,
    input  logic [63:0]          ext_rdata,
    output logic                 rsp_valid,
    output logic                 rsp_fault,
    output logic [63:0]          rsp_rdata
);
    msr_tgt_e            tgt;
    logic [SLOT_W-1:0]   slot;
    logic [EXT_SEL_W-1:0] sel;
    logic                priv_ok;
    logic                accept;
    logic                fault;
    logic [XLEN-1:0]     local_rd;
    logic [XLEN-1:0]     rd_mux;

    msr_index_decode u_dec (
        .index (req_index),
        .tgt   (tgt),
        .slot  (slot),
        .sel   (sel)
    );

    assign priv_ok = (req_priv == 2'd0);
    assign accept  = req_valid && priv_ok && (tgt != TGT_NONE);
    assign fault   = req_valid && !accept;

    msr_local_regs #(.MCA_W(MCA_W), .TRC_W(TRC_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .mc_capture (mc_capture),
        .mc_addr    (mc_addr[MCA_W-1:0]),
        .mc_attr    ({mc_lock, mc_mio, mc_dc, mc_wr}),
        .wr_en      (accept && req_write),
        .tgt        (tgt),
        .slot       (slot),
        .wdata      (req_wdata),
        .chk_clr    (accept && !req_write && tgt == TGT_MCTYPE),
        .rdata      (local_rd)
    );

    assign ext_valid = accept && (tgt == TGT_EXT);
    assign ext_write = req_write;
    assign ext_sel   = sel;
    assign ext_wdata = req_wdata;

    assign rd_mux = (tgt == TGT_EXT) ? ext_rdata : local_rd;

    // Register the single response: data or fault, never both.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_fault <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_fault <= fault;
            rsp_rdata <= (accept && !req_write) ? rd_mux : '0;
        end
    end
endmodule

// File: rtl/msr_access_sva.sv
// Checker: port-level properties of the access unit, bound to the top.
module msr_access_sva (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_write,
    input logic [31:0] req_index,
    input logic [1:0]  req_priv,
    input logic        mc_capture,
    input logic        ext_valid,
    input logic        rsp_valid,
    input logic        rsp_fault,
    input logic [63:0] rsp_rdata
);
    assert_rsp_follows_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    assert_no_spurious_rsp_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    assert_fault_no_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_rdata == 64'd0));
    assert_idle_no_fault_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> !rsp_fault);
    assert_priv_fault_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_priv != 2'd0) |=> rsp_fault);
    assert_hole_fault_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_index == 32'h3 || req_index == 32'hF || req_index > 32'h13))
        |=> rsp_fault);
    assert_fwd_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ext_valid |-> (req_valid && req_priv == 2'd0 &&
                       req_index >= 32'h10 && req_index <= 32'h13));
    assert_type_upper_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_priv == 2'd0 && req_index == 32'h1)
        |=> (rsp_rdata[63:5] == 59'd0 && !rsp_fault));
endmodule

bind msr_access_unit msr_access_sva chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_index  (req_index),
    .req_priv   (req_priv),
    .mc_capture (mc_capture),
    .ext_valid  (ext_valid),
    .rsp_valid  (rsp_valid),
    .rsp_fault  (rsp_fault),
    .rsp_rdata  (rsp_rdata)
);

// File: tb/msr_access_unit_tb_top.sv
module msr_access_unit_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [31:0] req_index = '0;
    logic [1:0]  req_priv = '0;
    logic [63:0] req_wdata = '0;
    logic        mc_capture = 1'b0;
    logic [31:0] mc_addr = '0;
    logic        mc_lock = 1'b0, mc_mio = 1'b0, mc_dc = 1'b0, mc_wr = 1'b0;
    logic        ext_valid, ext_write;
    logic [1:0]  ext_sel;
    logic [63:0] ext_wdata, ext_rdata;
    logic        rsp_valid, rsp_fault;
    logic [63:0] rsp_rdata;

    int n_chk = 0;
    int n_bad = 0;

    // Captured results of the last request.
    logic        r_valid, r_fault;
    logic [63:0] r_data;
    logic        x_valid, x_write;
    logic [1:0]  x_sel;
    logic [63:0] x_wdata;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Model of the forwarded targets: fixed function of the select.
    assign ext_rdata = {8'hE0, 54'd0, ext_sel};

    msr_access_unit dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_index(req_index), .req_priv(req_priv), .req_wdata(req_wdata),
        .mc_capture(mc_capture), .mc_addr(mc_addr), .mc_lock(mc_lock),
        .mc_mio(mc_mio), .mc_dc(mc_dc), .mc_wr(mc_wr),
        .ext_valid(ext_valid), .ext_write(ext_write), .ext_sel(ext_sel),
        .ext_wdata(ext_wdata), .ext_rdata(ext_rdata),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_rdata(rsp_rdata)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Present one request for one cycle; collect forwarding and response.
    task automatic do_req(input bit wr, input logic [31:0] idx, input logic [1:0] pl,
                          input logic [63:0] wd);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_index = idx; req_priv = pl; req_wdata = wd;
        #1;
        x_valid = ext_valid; x_write = ext_write; x_sel = ext_sel; x_wdata = ext_wdata;
        @(negedge clk);
        r_valid = rsp_valid; r_fault = rsp_fault; r_data = rsp_rdata;
        req_valid = 1'b0; req_write = 1'b0; req_index = '0; req_wdata = '0;
    endtask

    task automatic expect_rd(input logic [31:0] idx, input logic [63:0] exp, input string tag);
        do_req(1'b0, idx, 2'd0, 64'd0);
        check(r_valid && !r_fault && r_data == exp, tag, r_data, exp);
    endtask

    task automatic capture(input logic [31:0] a, input logic [3:0] attr);
        @(negedge clk);
        mc_capture = 1'b1; mc_addr = a; {mc_lock, mc_mio, mc_dc, mc_wr} = attr;
        @(negedge clk);
        mc_capture = 1'b0;
    endtask

    task automatic test_reset();
        check(!rsp_valid, "R10 rsp_valid after reset", {63'd0, rsp_valid}, 64'd0);
        expect_rd(32'h0, 64'd0, "R10 mc addr zero");
        expect_rd(32'h1, 64'd0, "R10 mc type zero");
        expect_rd(32'h2, 64'd0, "R10 test reg zero");
        expect_rd(32'hE, 64'd0, "R10 trace zero");
    endtask

    task automatic test_index_map();
        logic [31:0] bad_idx [5] = '{32'h3, 32'hF, 32'h14, 32'h1000, 32'h8000_0001};
        logic [31:0] good_idx [6] = '{32'h0, 32'h2, 32'h4, 32'hD, 32'hE, 32'h13};
        foreach (bad_idx[i]) begin
            do_req(1'b0, bad_idx[i], 2'd0, 64'd0);
            check(r_valid && r_fault && r_data == 0, "R1 hole faults", r_data, 64'd1);
            check(!x_valid, "R1 hole not forwarded", {63'd0, x_valid}, 64'd0);
        end
        foreach (good_idx[i]) begin
            do_req(1'b0, good_idx[i], 2'd0, 64'd0);
            check(r_valid && !r_fault, "R1 implemented accepted", {63'd0, r_fault}, 64'd0);
        end
    endtask

    task automatic test_priv();
        for (int p = 1; p < 4; p++) begin
            do_req(1'b1, 32'h5, 2'(p), 64'hDEAD_BEEF_0000_0000 | 64'(p));
            check(r_fault && r_data == 0, "R2 priv write faults", {63'd0, r_fault}, 64'd1);
            expect_rd(32'h5, 64'd0, "R2 faulted write left reg unchanged");
            do_req(1'b0, 32'h11, 2'(p), 64'd0);
            check(r_fault && !x_valid, "R2 priv not forwarded", {63'd0, x_valid}, 64'd0);
        end
        do_req(1'b1, 32'h2, 2'd0, 64'h1);
        check(r_valid && !r_fault && r_data == 0, "R3 accepted write response", r_data, 64'd0);
        @(negedge clk);
        check(!rsp_valid, "R3 response lasts one cycle", {63'd0, rsp_valid}, 64'd0);
    endtask

    task automatic test_mc_regs();
        capture(32'hCAFE_1234, 4'b1010);
        expect_rd(32'h0, 64'h0000_0000_CAFE_1234, "R4 mc addr captured");
        do_req(1'b1, 32'h0, 2'd0, 64'hFFFF_FFFF_FFFF_FFFF);
        check(!r_fault, "R4 write accepted", {63'd0, r_fault}, 64'd0);
        expect_rd(32'h0, 64'h0000_0000_CAFE_1234, "R4 write ignored");
        do_req(1'b1, 32'h1, 2'd0, 64'h0);
        expect_rd(32'h1, 64'h15, "R5 type attrs and flag, write ignored");
    endtask

    task automatic test_chk_clear();
        expect_rd(32'h1, 64'h14, "R6 flag cleared by read");
        capture(32'h0000_0040, 4'b0101);
        do_req(1'b0, 32'h1, 2'd2, 64'd0);
        check(r_fault, "R6 faulted read", {63'd0, r_fault}, 64'd1);
        expect_rd(32'h1, 64'h0B, "R6 faulted read kept flag");
        capture(32'h0000_0080, 4'b0011);
        // Capture coincident with an accepted read of the type record.
        @(negedge clk);
        mc_capture = 1'b1; mc_addr = 32'h0000_00C0; {mc_lock, mc_mio, mc_dc, mc_wr} = 4'b1000;
        req_valid = 1'b1; req_write = 1'b0; req_index = 32'h1; req_priv = 2'd0;
        @(negedge clk);
        mc_capture = 1'b0; req_valid = 1'b0; req_index = '0;
        check(rsp_rdata == 64'h07, "R6 read returns pre-capture value", rsp_rdata, 64'h07);
        expect_rd(32'h1, 64'h11, "R6 capture wins over clear");
        expect_rd(32'h0, 64'h0000_00C0, "R4 second capture address");
    endtask

    task automatic test_test_regs();
        for (int i = 2; i <= 13; i++)
            if (i != 3) do_req(1'b1, 32'(i), 2'd0, {32'h5A5A_0000 | 32'(i), ~32'(i)});
        for (int i = 2; i <= 13; i++)
            if (i != 3) expect_rd(32'(i), {32'h5A5A_0000 | 32'(i), ~32'(i)}, "R7 test readback");
    endtask

    task automatic test_trace();
        do_req(1'b1, 32'hE, 2'd0, 64'hFFFF_FFFF_FFFF_FFF2);
        expect_rd(32'hE, 64'h2, "R8 trace bit kept, reserved dropped");
        do_req(1'b1, 32'hE, 2'd0, 64'h0000_0000_0000_001D);
        expect_rd(32'hE, 64'hD, "R8 low bits stored");
    endtask

    task automatic test_forward();
        for (int s = 0; s < 4; s++) begin
            do_req(1'b0, 32'h10 + 32'(s), 2'd0, 64'd0);
            check(x_valid && !x_write && x_sel == 2'(s), "R9 read forwarded", {62'd0, x_sel}, 64'(s));
            check(!r_fault && r_data == {8'hE0, 54'd0, 2'(s)}, "R9 read data", r_data,
                  {8'hE0, 54'd0, 2'(s)});
            do_req(1'b1, 32'h10 + 32'(s), 2'd0, 64'h0123_4567_89AB_CDE0 + 64'(s));
            check(x_valid && x_write && x_wdata == 64'h0123_4567_89AB_CDE0 + 64'(s),
                  "R9 write forwarded", x_wdata, 64'h0123_4567_89AB_CDE0 + 64'(s));
            check(!r_fault && r_data == 0, "R9 write response", r_data, 64'd0);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=%h expected=%h", 64'd1, 64'd0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        test_index_map();
        test_priv();
        test_mc_regs();
        test_chk_clear();
        test_test_regs();
        test_trace();
        test_forward();
        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule